// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This unit produces data-memory addresses for a signal-processing data path. It holds a small file of address registers and a separate file of block-size registers. On each request it reads one address register, presents that value as the effective address, and writes a modified value back at the next clock edge. The modification is one of three kinds. Linear mode adds a signed step. Circular mode adds the step and wraps inside a block that runs from zero up to a block size, and that size need not be a power of two. Bit-reversed mode adds the step at the top of a programmable low bit field, so the carry runs toward bit 0, and the bits above the field are left alone.

The request chooses the block-size register on every access, so one address register can move through blocks of different sizes. A write port loads either register file. A write to an address register wins over an update of that same register in the same cycle. Memory access, instruction decode and arithmetic on data are handled elsewhere.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset, every address register and every block-size register reads as zero.
- R2: While `upd_valid` is high, `ea_out` shows the selected register's value before it is modified, and that register holds `next_out` after the next rising clock edge.
- R3: Mode 0 (linear) gives `next_out` = address + step, taken modulo 2^16.
- R4: Mode 1 (circular) with a non-negative step: if address + step is greater than or equal to the block size, the result is address + step − block size. Otherwise it is address + step.
- R5: Mode 1 (circular) with a negative step: if address + step is below zero, the result is address + step + block size. This assumes the address is inside the block and the step's magnitude is less than the block size.
- R6: `upd_bsel` picks, on each request, which of the four block-size registers sets the wrap bound. Any non-zero size works, including sizes that are not powers of two.
- R7: Mode 2 (bit-reversed) takes the field of bits `upd_brpos` down to 0 and reverses it, adds the step, drops any carry out of the field, and reverses the field back. Bits above `upd_brpos` are unchanged. With a step of 1, this adds one at bit `upd_brpos` and the carry runs toward bit 0.
- R8: Mode 3 (hold) gives `next_out` equal to `ea_out`.
- R9: With `wr_en` high, `wr_blk` = 0 loads address register `wr_idx` and `wr_blk` = 1 loads block-size register `wr_idx[1:0]`. The new value is visible from the next cycle.
- R10: An address-register write and an update that target the same register in the same cycle leave that register holding the write data.
- R11: While `upd_valid` is low, no address register changes. `ea_out` still shows the register selected by `upd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| upd_valid | input | 1 | Apply the post-modify update this cycle |
| upd_idx | input | 3 | Address register to read and update |
| upd_mode | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 hold |
| upd_step | input | 16 | Signed step, two's complement |
| upd_bsel | input | 2 | Block-size register used for the circular wrap |
| upd_brpos | input | 4 | Top bit of the bit-reversed field |
| wr_en | input | 1 | Register write strobe |
| wr_blk | input | 1 | 0 selects the address file, 1 selects the block-size file |
| wr_idx | input | 3 | Register written |
| wr_data | input | 16 | Write value |
| ea_out | output | 16 | Effective address (value before modification) |
| next_out | output | 16 | Modified value that will be written back |

## Verification
The write port and the update path can hit the same address register in the same cycle. The bench forces this directly by issuing a linear update and a write to the same index together. It also lets it happen in the random phase, where each cycle can carry both a write and an update. The bench judges the outcome from the `ea_out` value it sees on the next access: the write data must be there, and the updated value must not. A second overlap is a block-size write that lands in the same cycle as a circular update that reads that block register. The model expects the update to use the old size.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_CIRC = 2'd1,
    MODE_BREV = 2'd2,
    MODE_HOLD = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW    = 16,
  parameter int NAREG = 8,
  parameter int NBLK  = 4,
  localparam int IW   = $clog2(NAREG),
  localparam int BW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  input  logic [BW-1:0] rd_bsel,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] rd_bsize,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_data,
  input  logic          wr_en,
  input  logic          wr_blk,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data
);
  logic [AW-1:0] areg_q [NAREG];
  logic [AW-1:0] areg_d [NAREG];
  logic [AW-1:0] breg_q [NBLK];
  logic [AW-1:0] breg_d [NBLK];
  logic          a_we, b_we;

  assign rd_addr  = areg_q[rd_idx];
  assign rd_bsize = breg_q[rd_bsel];
  assign a_we     = upd_en | (wr_en & ~wr_blk);
  assign b_we     = wr_en & wr_blk;

  always_comb begin
    for (int i = 0; i < NAREG; i++) areg_d[i] = areg_q[i];
    for (int i = 0; i < NBLK; i++)  breg_d[i] = breg_q[i];
    if (upd_en) areg_d[rd_idx] = upd_data;
    if (wr_en && !wr_blk) areg_d[wr_idx] = wr_data;
    if (wr_en && wr_blk) breg_d[wr_idx[BW-1:0]] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NAREG; i++) areg_q[i] <= '0;
    end else if (a_we) begin
      for (int i = 0; i < NAREG; i++) areg_q[i] <= areg_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) breg_q[i] <= '0;
    end else if (b_we) begin
      for (int i = 0; i < NBLK; i++) breg_q[i] <= breg_d[i];
    end
  end

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_blk) |=> areg_q[$past(wr_idx)] == $past(wr_data));

  // R2
  upd_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(wr_en && !wr_blk && wr_idx == rd_idx))
      |=> areg_q[$past(rd_idx)] == $past(upd_data));
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW = 16,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] bsize,
  output logic [AW-1:0] res
);
  logic [EW-1:0] sum, ext_b;
  logic          neg_step;

  assign neg_step = step[AW-1];
  assign ext_b    = {2'b00, bsize};
  assign sum      = {2'b00, addr} + {{2{step[AW-1]}}, step};

  always_comb begin
    res = sum[AW-1:0];
    if (!neg_step) begin
      if (sum >= ext_b) res = AW'(sum - ext_b);
    end else begin
      if (sum[EW-1]) res = AW'(sum + ext_b);
    end
  end
endmodule

// File: rtl/agu_brev.sv
module agu_brev #(
  parameter int AW = 16,
  localparam int PW = $clog2(AW)
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] step,
  input  logic [PW-1:0] pos,
  output logic [AW-1:0] res
);
  logic [AW-1:0] field_mask, fwd, sum, back;

  function automatic logic [AW-1:0] mirror(input logic [AW-1:0] x,
                                           input logic [PW-1:0] p);
    logic [AW-1:0] r;
    logic [PW-1:0] j;
    r = '0;
    for (int i = 0; i < AW; i++) begin
      j = p - PW'(i);
      if (PW'(i) <= p) r[i] = x[j];
    end
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < AW; i++) field_mask[i] = (PW'(i) <= pos);
  end

  assign fwd  = mirror(addr, pos);
  assign sum  = fwd + step;
  assign back = mirror(sum, pos);
  assign res  = (addr & ~field_mask) | (back & field_mask);
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW    = 16,
  parameter int NAREG = 8,
  parameter int NBLK  = 4,
  localparam int IW   = $clog2(NAREG),
  localparam int BW   = $clog2(NBLK),
  localparam int PW   = $clog2(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic [IW-1:0] upd_idx,
  input  logic [1:0]    upd_mode,
  input  logic [AW-1:0] upd_step,
  input  logic [BW-1:0] upd_bsel,
  input  logic [PW-1:0] upd_brpos,
  input  logic          wr_en,
  input  logic          wr_blk,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] ea_out,
  output logic [AW-1:0] next_out
);
  import agu_pkg::*;

  logic          rst_meta_q, rst_sync_q;
  logic [AW-1:0] cur_addr, cur_bsize, circ_res, brev_res, lin_res;
  agu_mode_e     mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  agu_regfile #(.AW(AW), .NAREG(NAREG), .NBLK(NBLK)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .rd_idx   (upd_idx),
    .rd_bsel  (upd_bsel),
    .rd_addr  (cur_addr),
    .rd_bsize (cur_bsize),
    .upd_en   (upd_valid),
    .upd_data (next_out),
    .wr_en    (wr_en),
    .wr_blk   (wr_blk),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  agu_circ #(.AW(AW)) u_circ (
    .addr  (cur_addr),
    .step  (upd_step),
    .bsize (cur_bsize),
    .res   (circ_res)
  );

  agu_brev #(.AW(AW)) u_brev (
    .addr (cur_addr),
    .step (upd_step),
    .pos  (upd_brpos),
    .res  (brev_res)
  );

  assign mode    = agu_mode_e'(upd_mode);
  assign lin_res = cur_addr + upd_step;
  assign ea_out  = cur_addr;

  always_comb begin
    unique case (mode)
      MODE_LIN:  next_out = lin_res;
      MODE_CIRC: next_out = circ_res;
      MODE_BREV: next_out = brev_res;
      default:   next_out = cur_addr;
    endcase
  end

  // R4 R5
  circ_in_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (upd_valid && upd_mode == 2'd1 && cur_bsize != '0 && ea_out < cur_bsize &&
     (upd_step[AW-1] ? AW'(-upd_step) : upd_step) < cur_bsize)
      |-> next_out < cur_bsize);

  // R7
  brev_upper_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (upd_valid && upd_mode == 2'd2)
      |-> (next_out >> ({1'b0, upd_brpos} + 5'd1)) == (ea_out >> ({1'b0, upd_brpos} + 5'd1)));
endmodule

// File: tb/addr_gen_unit_bench.sv
module addr_gen_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid, wr_en, wr_blk;
  logic [2:0]  upd_idx, wr_idx;
  logic [1:0]  upd_mode, upd_bsel;
  logic [15:0] upd_step, wr_data;
  logic [3:0]  upd_brpos;
  logic [15:0] ea_out, next_out;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_a [8];
  logic [15:0] m_b [4];
  bit done = 0;

  always #10 clk = ~clk;

  addr_gen_unit u_addr_gen_unit (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_mode(upd_mode), .upd_step(upd_step), .upd_bsel(upd_bsel),
    .upd_brpos(upd_brpos), .wr_en(wr_en), .wr_blk(wr_blk), .wr_idx(wr_idx),
    .wr_data(wr_data), .ea_out(ea_out), .next_out(next_out)
  );

  function automatic logic [15:0] flip(input logic [15:0] x, input int p);
    logic [15:0] r = '0;
    for (int k = 0; k <= p; k++) r[p - k] = x[k];
    return r;
  endfunction

  function automatic logic [15:0] expect_next(input logic [1:0] md, input logic [15:0] a,
      input logic [15:0] st, input logic [15:0] bs, input int p);
    int s;
    logic [15:0] low, lowmask;
    case (md)
      2'd0: return a + st;
      2'd1: begin
        s = int'(a) + int'($signed(st));
        if (s >= int'(bs)) s = s - int'(bs);
        else if (s < 0) s = s + int'(bs);
        return s[15:0];
      end
      2'd2: begin
        lowmask = 16'((32'd1 << (p + 1)) - 1);
        low = flip(flip(a, p) + st, p) & lowmask;
        return (a & ~lowmask) | low;
      end
      default: return a;
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [2:0] idx, input logic [1:0] md,
      input logic [15:0] st, input logic [1:0] bs, input logic [3:0] p,
      input logic we, input logic wb, input logic [2:0] wi, input logic [15:0] wd,
      input string tag);
    logic [15:0] nx;
    @(negedge clk);
    upd_valid = v; upd_idx = idx; upd_mode = md; upd_step = st; upd_bsel = bs;
    upd_brpos = p; wr_en = we; wr_blk = wb; wr_idx = wi; wr_data = wd;
    nx = expect_next(md, m_a[idx], st, m_b[bs], int'(p));
    #5;
    check(ea_out, m_a[idx], tag);
    if (v) check(next_out, nx, tag);
    @(posedge clk);
    if (v) m_a[idx] = nx;
    if (we && !wb) m_a[wi] = wd;
    if (we && wb) m_b[wi[1:0]] = wd;
  endtask

  task automatic wa(input logic [2:0] i, input logic [15:0] d);
    cyc(0, i, 0, 0, 0, 0, 1, 0, i, d, "R9");
  endtask

  task automatic wb_(input logic [1:0] i, input logic [15:0] d);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, {1'b0, i}, d, "R9");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    for (int i = 0; i < 8; i++) m_a[i] = '0;
    for (int i = 0; i < 4; i++) m_b[i] = '0;
    upd_valid = 0; upd_idx = 0; upd_mode = 0; upd_step = 0; upd_bsel = 0;
    upd_brpos = 0; wr_en = 0; wr_blk = 0; wr_idx = 0; wr_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < 8; i++) cyc(0, 3'(i), 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 4; i++) cyc(1, 0, 2'd3, 0, 2'(i), 0, 0, 0, 0, 0, "R1");

    wb_(0, 16'd10); wb_(1, 16'd7); wb_(2, 16'd1000); wb_(3, 16'd16);
    wa(0, 16'd8);
    cyc(1, 0, 2'd1, 16'd3, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 2'd1, -16'sd3, 0, 0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 2'd1, -16'sd9, 0, 0, 0, 0, 0, 0, "R5");
    wa(1, 16'd5);
    cyc(1, 1, 2'd1, 16'd4, 2'd1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 1, 2'd1, 16'd4, 2'd0, 0, 0, 0, 0, 0, "R6");
    cyc(1, 1, 2'd1, 16'd999, 2'd2, 0, 0, 0, 0, 0, "R6");
    wa(2, 16'hFFFE);
    cyc(1, 2, 2'd0, 16'd3, 0, 0, 0, 0, 0, 0, "R3");
    cyc(1, 2, 2'd0, -16'sd5, 0, 0, 0, 0, 0, 0, "R3");
    wa(3, 16'h1230);
    cyc(1, 3, 2'd2, 16'd1, 0, 4'd3, 0, 0, 0, 0, "R7");
    cyc(1, 3, 2'd2, 16'd1, 0, 4'd3, 0, 0, 0, 0, "R7");
    cyc(1, 3, 2'd2, 16'd1, 0, 4'd3, 0, 0, 0, 0, "R7");
    wa(5, 16'h0000);
    cyc(1, 5, 2'd2, 16'd1, 0, 4'd15, 0, 0, 0, 0, "R7");
    cyc(1, 5, 2'd2, 16'd1, 0, 4'd15, 0, 0, 0, 0, "R7");
    cyc(1, 3, 2'd3, 16'd7, 0, 4'd3, 0, 0, 0, 0, "R8");
    wa(4, 16'd100);
    cyc(1, 4, 2'd0, 16'd5, 0, 0, 1, 0, 3'd4, 16'h0055, "R10");
    cyc(0, 4, 2'd0, 16'd5, 0, 0, 0, 0, 0, 0, "R10");
    cyc(0, 4, 2'd0, 16'd9, 0, 0, 0, 0, 0, 0, "R11");
    cyc(0, 4, 2'd1, 16'd1, 0, 0, 0, 0, 0, 0, "R11");
    cyc(1, 0, 2'd1, 16'd1, 0, 0, 1, 1, 3'd0, 16'd3, "R6");
    cyc(1, 0, 2'd1, 16'd1, 0, 0, 0, 0, 0, 0, "R6");

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ri, rwi;
      logic [1:0] rm, rb;
      logic [15:0] rs, rd;
      logic [3:0] rp;
      logic rv, rwe, rwb;
      string tg;
      ri = 3'($urandom); rm = 2'($urandom); rb = 2'($urandom);
      rp = 4'($urandom); rs = 16'($urandom); rv = ($urandom % 4) != 0;
      rwe = ($urandom % 5) == 0; rwb = $urandom % 2; rwi = 3'($urandom);
      rd = rwb ? 16'(1 + $urandom % 2000) : 16'($urandom % 2000);
      if (rm == 2'd1) begin
        if (m_b[rb] < 2 || m_a[ri] >= m_b[rb]) rm = 2'd0;
        else begin
          rs = 16'($urandom % m_b[rb]);
          if ($urandom % 2) rs = -rs;
        end
      end
      case (rm)
        2'd0: tg = "R3";
        2'd1: tg = rs[15] ? "R5" : "R4";
        2'd2: tg = "R7";
        default: tg = "R8";
      endcase
      if (!rv) tg = "R11";
      else if (rwe && !rwb && rwi == ri) tg = "R10";
      cyc(rv, ri, rm, rs, rb, rp, rwe, rwb, rwi, rd, tg);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule